// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog timer with one 16-bit write port, a data word plus a write strobe. Every write passes through a small key sequencer. Two fixed word pairs are recognised:

- an unlock pair, which lets the next write land in the control register;
- a refresh pair, which restarts the running count and leaves the configuration as it is.

A write that breaks a pair returns the sequencer to idle, and that write does nothing else.

The control register enables the timer through its two top bits. It also carries a one-hot timeout-select field. While the timer is enabled, a prescaler turns every `PRESCALE` clocks into one tick. The counter counts these ticks up to a power-of-two period. When it gets there, the block raises `wd_reset_o` for one clock and starts counting again from zero. Software reconfigures the timer in two steps: one unlock sequence writes a disabling value, and a second unlock sequence writes the new setting. The control register can always be read back on `ctrl_o`.

Top module: `wdt_keyed`

## Requirements
- R1: After reset `ctrl_o` is 0, `wd_reset_o` is low and the key sequencer is idle.
- R2: The unlock pair is a write of 16'h3333 followed by a write of 16'hCCCC, as the next two writes. After it, exactly one further write is stored whole into the control register. Later writes do not change the register until a new unlock pair arrives.
- R3: The refresh pair is a write of 16'hAAAA followed by a write of 16'h5555, as the next two writes. It clears the prescaler and the tick counter, and it leaves `ctrl_o` unchanged.
- R4: A write that does not match the next expected key word sends the sequencer back to idle, and that write has no other effect. Cycles with `wr_en_i` low do not advance the sequencer and do not reset it.
- R5: The timer runs only while control bits 15 and 14 are both 1. Writing 16'h0000 or 16'h4080 through an unlock pair stops it, and after that no pulse appears.
- R6: Control bits [SEL_W:1] form the timeout select. When bit k is set, the period is 2^(BASE_EXP+k) ticks. If several bits are set, the lowest one wins. If no bit is set, the timer never fires.
- R7: One tick occurs every `PRESCALE` clocks of running time.
- R8: Suppose the last control write or completed refresh is at clock edge E. Then `wd_reset_o` is high for exactly the one cycle after edge E + PRESCALE·period·n, for each n ≥ 1, until the next control write or refresh.
- R9: A write into the control register clears the prescaler and the tick counter, so a new setting times from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per high cycle |
| wr_data_i | input | 16 | Write data word |
| wd_reset_o | output | 1 | Timeout pulse, one clock wide |
| ctrl_o | output | 16 | Control register readback |

## Verification
The assertions assume three things about the inputs:

- `wr_data_i` holds a known value in every cycle where `wr_en_i` is high.
- Back-to-back writes are legal.
- `SEL_W` is small enough (at most 13) that the select field stays clear of the two enable bits.

The bench drives the strobe and data only on falling edges, so each write is exactly one clock long. It also keeps the bench-side parameters small, so that the longest period still expires within the run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [15:0] KEY_UNLOCK_A  = 16'h3333;
  localparam logic [15:0] KEY_UNLOCK_B  = 16'hCCCC;
  localparam logic [15:0] KEY_REFRESH_A = 16'hAAAA;
  localparam logic [15:0] KEY_REFRESH_B = 16'h5555;

  typedef enum logic [1:0] {
    KS_IDLE,
    KS_UNLOCK1,
    KS_OPEN,
    KS_REFRESH1
  } key_st_e;
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic        ctrl_we_o,
  output logic        refresh_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    ctrl_we_o = 1'b0;
    refresh_o = 1'b0;
    if (wr_en_i) begin
      unique case (st_q)
        KS_IDLE: begin
          if (wr_data_i == KEY_UNLOCK_A)       st_d = KS_UNLOCK1;
          else if (wr_data_i == KEY_REFRESH_A) st_d = KS_REFRESH1;
          else                                 st_d = KS_IDLE;
        end
        KS_UNLOCK1: st_d = (wr_data_i == KEY_UNLOCK_B) ? KS_OPEN : KS_IDLE;
        KS_OPEN: begin
          ctrl_we_o = 1'b1;
          st_d      = KS_IDLE;
        end
        KS_REFRESH1: begin
          refresh_o = (wr_data_i == KEY_REFRESH_B);
          st_d      = KS_IDLE;
        end
        default: st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= KS_IDLE;
    else         st_q <= st_d;

  // one write only while open
  p_open_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == KS_OPEN && wr_en_i) |=> (st_q == KS_IDLE));

  // mismatched second word drops to idle
  p_bad_word_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == KS_UNLOCK1 || st_q == KS_REFRESH1) && wr_en_i) |=> (st_q != KS_UNLOCK1 && st_q != KS_REFRESH1));

  // idle cycles hold the state
  p_no_write_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(st_q));
endmodule

// File: rtl/wdt_sel.sv
module wdt_sel #(
  parameter int SEL_W = 7,
  localparam int K_W  = $clog2(SEL_W + 1)
) (
  input  logic [SEL_W-1:0] field_i,   // field_i[k-1] is control bit k
  output logic [K_W-1:0]   sel_k_o,
  output logic             sel_vld_o
);
  always_comb begin
    sel_k_o   = '0;
    sel_vld_o = 1'b0;
    for (int k = SEL_W; k >= 1; k--) begin
      if (field_i[k-1]) begin
        sel_k_o   = K_W'(k);
        sel_vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int PRESCALE = 4,
  parameter int CNT_W    = 31,
  localparam int PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             wd_reset_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (pre_q == PRE_W'(PRESCALE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q      <= '0;
      cnt_q      <= '0;
      wd_reset_o <= 1'b0;
    end else begin
      wd_reset_o <= 1'b0;
      if (clear_i || !run_i) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick) begin
        pre_q <= '0;
        if (cnt_q >= term_i) begin
          cnt_q      <= '0;
          wd_reset_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  p_pulse_one_clk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_reset_o |=> !wd_reset_o);

  p_stopped_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!wd_reset_o && cnt_q == '0));

  p_clear_restarts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0 && pre_q == '0 && !wd_reset_o));

  p_no_overrun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= term_i));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int BASE_EXP = 23,
  parameter int SEL_W    = 7,   // at most 13
  parameter int PRESCALE = 4,
  localparam int CNT_W   = BASE_EXP + SEL_W + 1,
  localparam int K_W     = $clog2(SEL_W + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic        wd_reset_o,
  output logic [15:0] ctrl_o
);
  logic             ctrl_we, refresh;
  logic [15:0]      ctrl_q;
  logic [K_W-1:0]   sel_k;
  logic             sel_vld, run;
  logic [CNT_W-1:0] term;

  wdt_keyseq u_keys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctrl_we_o (ctrl_we),
    .refresh_o (refresh)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wr_data_i;

  wdt_sel #(.SEL_W(SEL_W)) u_sel (
    .field_i   (ctrl_q[SEL_W:1]),
    .sel_k_o   (sel_k),
    .sel_vld_o (sel_vld)
  );

  assign run  = ctrl_q[15] & ctrl_q[14] & sel_vld;
  assign term = (CNT_W'(1) << (BASE_EXP + int'(sel_k))) - CNT_W'(1);

  wdt_count #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .clear_i    (ctrl_we | refresh),
    .term_i     (term),
    .wd_reset_o (wd_reset_o)
  );

  assign ctrl_o = ctrl_q;

  p_ctrl_only_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> $past(ctrl_we));

  p_refresh_keeps_cfg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh |=> $stable(ctrl_q));

  p_one_action_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_we && refresh));
endmodule

// File: tb/sim_wdt_keyed.sv
module sim_wdt_keyed;
  localparam int BASE = 2;
  localparam int SELW = 7;
  localparam int PRE  = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wd_reset;
  logic [15:0] ctrl;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  wdt_keyed #(.BASE_EXP(BASE), .SEL_W(SELW), .PRESCALE(PRE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wd_reset_o(wd_reset), .ctrl_o(ctrl)
  );

  // behavioural reference
  int m_st, m_pre, m_cnt;
  int m_ctrl;
  bit m_pulse;

  function automatic int period_of(int c);
    for (int k = 1; k <= SELW; k++)
      if (c[k]) return 1 << (BASE + k);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_pre = 0; m_cnt = 0; m_ctrl = 0; m_pulse = 0;
    end else begin
      bit clr;
      int per;
      clr = 0;
      per = period_of(m_ctrl);
      m_pulse = 0;
      if (wr_en) begin
        case (m_st)
          0: m_st = (wr_data == 16'h3333) ? 1 : (wr_data == 16'hAAAA) ? 3 : 0;
          1: m_st = (wr_data == 16'hCCCC) ? 2 : 0;
          2: begin m_ctrl = int'(wr_data); clr = 1; m_st = 0; end
          default: begin clr = (wr_data == 16'h5555); m_st = 0; end
        endcase
      end
      if (clr || !(m_ctrl[15] && m_ctrl[14] && per != 0)) begin
        m_pre = 0; m_cnt = 0;
      end else if (m_pre == PRE - 1) begin
        m_pre = 0;
        if (m_cnt == per - 1) begin m_cnt = 0; m_pulse = 1; end
        else m_cnt++;
      end else m_pre++;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_ni) begin
      checks++;
      if (wd_reset !== m_pulse || ctrl !== 16'(m_ctrl)) begin
        errors++;
        $display("FAIL %s: pulse=%0b ctrl=%h expected pulse=%0b ctrl=%h",
                 cur_req, wd_reset, ctrl, m_pulse, 16'(m_ctrl));
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%h) expected=%0d (0x%h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_ctrl(logic [15:0] d);
    wr(16'h3333); wr(16'hCCCC); wr(d);
  endtask

  task automatic count_pulses(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wd_reset) c++;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check("R1 ctrl", int'(ctrl), 0);
    check("R1 pulse", int'(wd_reset), 0);
    rst_ni = 1'b1;
    cmp_on = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ctrl after release", int'(ctrl), 0);

    cur_req = "R2";
    set_ctrl(16'hC002);
    check("R2 stored", int'(ctrl), 16'hC002);
    wr(16'hFFFF);
    check("R2 one write only", int'(ctrl), 16'hC002);

    cur_req = "R8";
    set_ctrl(16'hC002);
    count_pulses(400, c);
    check("R8 pulses k=1 over 400 clocks", c, 25);

    cur_req = "R7";
    count_pulses(300, c);

    cur_req = "R3";
    set_ctrl(16'hC002);
    c = 0;
    for (int r = 0; r < 20; r++) begin
      int t;
      wr(16'hAAAA); wr(16'h5555);
      count_pulses(8, t);
      c += t;
    end
    check("R3 refreshed never fires", c, 0);
    check("R3 ctrl kept", int'(ctrl), 16'hC002);

    cur_req = "R4";
    wr(16'h3333); wr(16'h1234); wr(16'hCCCC); wr(16'h0000);
    check("R4 broken unlock ignored", int'(ctrl), 16'hC002);
    wr(16'hAAAA); wr(16'h0000); wr(16'h5555);
    @(negedge clk); wr(16'h3333); repeat (5) @(negedge clk); wr(16'hCCCC); wr(16'hC004);
    check("R4 idle gaps keep sequence", int'(ctrl), 16'hC004);
    count_pulses(200, c);

    cur_req = "R9";
    repeat (13) @(negedge clk);
    set_ctrl(16'h0000);
    set_ctrl(16'hC002);
    count_pulses(16, c);
    check("R9 first pulse from new write", c, 1);

    cur_req = "R5";
    set_ctrl(16'h4080);
    check("R5 ctrl 0x4080", int'(ctrl), 16'h4080);
    count_pulses(2000, c);
    check("R5 0x4080 stopped", c, 0);
    set_ctrl(16'h8002);
    count_pulses(500, c);
    check("R5 bit14 clear stopped", c, 0);

    cur_req = "R6";
    set_ctrl(16'hC00C);
    count_pulses(400, c);
    check("R6 lowest bit wins", c, 12);
    set_ctrl(16'hC000);
    count_pulses(1500, c);
    check("R6 empty field", c, 0);
    set_ctrl(16'hC100);
    count_pulses(1500, c);
    check("R6 bit above field", c, 0);
    set_ctrl(16'hC080);
    count_pulses(2100, c);
    check("R6 top select k=7", c, 2);

    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule